// File: doc/BRIEF.md
# Indexed Interrupt Redirection Register File

This block is the register file of an I/O interrupt router. Software on a 32-bit bus reaches it through two byte offsets. It writes a register number to the index register at offset 0x00. It then reads or writes the selected 32-bit register through the data window at offset 0x10. The indexed space holds three things: a unit identifier register, a read-only version register that gives the size of the table, and one 64-bit redirection entry for each input line. Each entry is split across two consecutive indices.

On the interrupt side, each line exposes its entry's vector, destination and mask state. An input that is high and unmasked raises a registered request. A fixed-priority selector then picks the lowest-numbered active request and presents its line number, vector and destination. Delivery of the message to processors, and acknowledge of level-triggered lines, happen outside this block.

Top module: `irq_route_table`

## Requirements
- R1: Offset 0x00 holds the index register, whose low 8 bits are written and read back. Offset 0x10 is the data window onto the indexed register. Any other offset reads as zero, and a write to it changes nothing.
- R2: Index 0x00 is the identifier register. Bits 31:24 are writable and are readable through the window. Bits 23:0 always read zero.
- R3: Index 0x01 is the version register. It is read-only and reads bits 23:16 = NUM_LINES-1 (23 by default) and bits 7:0 = VERSION (0x20 by default); every other bit is zero.
- R4: Entry n's low word sits at index 0x10+2n. It holds the vector in bits 7:0, the trigger mode in bit 15 and the mask in bit 16. Its other bits read zero.
- R5: Entry n's high word sits at index 0x11+2n. It holds the destination in bits 31:24, and all other bits read zero.
- R6: After reset the index register and the identifier are zero. Every entry has its mask bit set and every other field clear, so a low word reads 0x00010000.
- R7: Indices 0x02 to 0x0F, and indices from 0x10+2·NUM_LINES upward, read zero through the window. A write to any of them leaves every register unchanged.
- R8: req_out[n] rises one clock after irq_in[n] is high while entry n is unmasked. It stays low whenever the entry was masked in the previous cycle.
- R9: line_vector, line_dest and line_masked for line n show entry n's fields in the cycle that follows the window write that set them.
- R10: pick_valid is high exactly when some req_out bit is set. pick_line is then the lowest-numbered set bit, and pick_vector and pick_dest are that line's entry fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for bus_addr and bus_wdata |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | NUM_LINES | Interrupt input lines |
| req_out | output | NUM_LINES | Registered per-line requests |
| line_masked | output | NUM_LINES | Mask bit of each entry |
| line_vector | output | 8·NUM_LINES | Vector of each entry, line n in bits 8n+7:8n |
| line_dest | output | 8·NUM_LINES | Destination of each entry, line n in bits 8n+7:8n |
| pick_valid | output | 1 | Some request is active |
| pick_line | output | $clog2(NUM_LINES) | Lowest active request line |
| pick_vector | output | 8 | Vector of the picked line |
| pick_dest | output | 8 | Destination of the picked line |

## Verification
The bench builds the block with its defaults: 24 lines, a table base of 0x10 and an 8-bit index. With these values the last low word is at 0x3E and the last high word at 0x3F. That places the first unmapped table index, 0x40, and the gap from 0x02 to 0x0F next to real registers, so the edge of the decode is tested on both sides. A line count that is not a power of two means the entry selector has codes with no entry behind them, and this also exercises the lowest-first selector across a 24-bit request word.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Field positions inside the two words of a redirection entry
    localparam int VEC_LSB   = 0;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LSB  = 24;

    // Field positions inside the identifier and version registers
    localparam int ID_LSB    = 24;
    localparam int COUNT_LSB = 16;

    // Stored state of one entry: only implemented bits take flops
    typedef struct packed {
        logic [7:0] vector;
        logic       trigger;
        logic       mask;
        logic [7:0] dest;
    } rte_t;

    localparam rte_t RTE_RESET = '{vector: 8'h00, trigger: 1'b0, mask: 1'b1, dest: 8'h00};

    function automatic logic [31:0] rte_low_word(rte_t e);
        logic [31:0] w;
        w = '0;
        w[VEC_LSB +: 8] = e.vector;
        w[TRIG_BIT]     = e.trigger;
        w[MASK_BIT]     = e.mask;
        return w;
    endfunction

    function automatic logic [31:0] rte_high_word(rte_t e);
        logic [31:0] w;
        w = '0;
        w[DEST_LSB +: 8] = e.dest;
        return w;
    endfunction

endpackage

// File: rtl/irq_route_window.sv
module irq_route_window
    import irq_route_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int IDX_W      = 8,
    parameter int NUM_LINES  = 24,
    parameter int ENT_W      = 5,
    parameter int IDX_OFS    = 'h00,
    parameter int WIN_OFS    = 'h10,
    parameter int ID_IDX     = 'h00,
    parameter int VER_IDX    = 'h01,
    parameter int TABLE_BASE = 'h10,
    parameter int VERSION    = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       tbl_rdata,
    output logic [31:0]       bus_rdata,
    output logic              tbl_wr,
    output logic [ENT_W-1:0]  tbl_entry,
    output logic              tbl_high
);

    localparam logic [IDX_W:0]    TBL_END  = (IDX_W+1)'(TABLE_BASE + 2*NUM_LINES);
    localparam logic [IDX_W-1:0]  TBL_BASE = IDX_W'(TABLE_BASE);
    localparam logic [ADDR_W-1:0] A_IDX    = ADDR_W'(IDX_OFS);
    localparam logic [ADDR_W-1:0] A_WIN    = ADDR_W'(WIN_OFS);
    localparam logic [IDX_W-1:0]  I_ID     = IDX_W'(ID_IDX);
    localparam logic [IDX_W-1:0]  I_VER    = IDX_W'(VER_IDX);
    localparam logic [31:0]       VER_WORD = (32'(NUM_LINES - 1) << COUNT_LSB) | 32'(VERSION & 'hFF);

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic [7:0]       id;
    } win_state_t;

    win_state_t s_d, s_q;

    logic             in_table;
    logic [IDX_W-1:0] rel_idx;
    logic [IDX_W-1:0] rel_half;
    logic             acc_win;
    logic [31:0]      win_rdata;

    always_comb begin
        in_table  = (s_q.index >= TBL_BASE) && ({1'b0, s_q.index} < TBL_END);
        rel_idx   = s_q.index - TBL_BASE;
        rel_half  = rel_idx >> 1;
        tbl_entry = rel_half[ENT_W-1:0];
        tbl_high  = rel_idx[0];
        acc_win   = (bus_addr == A_WIN);

        if (in_table)                 win_rdata = tbl_rdata;
        else if (s_q.index == I_ID)   win_rdata = 32'(s_q.id) << ID_LSB;
        else if (s_q.index == I_VER)  win_rdata = VER_WORD;
        else                          win_rdata = '0;

        if (bus_addr == A_IDX)        bus_rdata = 32'(s_q.index);
        else if (acc_win)             bus_rdata = win_rdata;
        else                          bus_rdata = '0;

        tbl_wr = bus_wr && acc_win && in_table;

        s_d = s_q;
        if (bus_wr && bus_addr == A_IDX)
            s_d.index = bus_wdata[IDX_W-1:0];
        if (bus_wr && acc_win && s_q.index == I_ID)
            s_d.id = bus_wdata[ID_LSB +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    AST_VER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_win && s_q.index == I_VER) |-> (bus_rdata[23:16] == 8'(NUM_LINES - 1))); // R3

    AST_ID_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_win && s_q.index == I_ID) |-> (bus_rdata[23:0] == 24'h0)); // R2

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_IDX) |=> $stable(s_q.index)); // R1

endmodule

// File: rtl/irq_route_entries.sv
module irq_route_entries
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int ENT_W     = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ENT_W-1:0]       sel_entry,
    input  logic                   sel_high,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic [NUM_LINES-1:0]   ent_mask,
    output logic [8*NUM_LINES-1:0] ent_vector,
    output logic [8*NUM_LINES-1:0] ent_dest
);

    typedef struct packed {
        rte_t [NUM_LINES-1:0] tbl;
    } tbl_state_t;

    tbl_state_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        rdata = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (sel_entry == ENT_W'(i)) begin
                rdata = sel_high ? rte_high_word(s_q.tbl[i]) : rte_low_word(s_q.tbl[i]);
                if (wr_en) begin
                    if (sel_high) begin
                        s_d.tbl[i].dest = wdata[DEST_LSB +: 8];
                    end else begin
                        s_d.tbl[i].vector  = wdata[VEC_LSB +: 8];
                        s_d.tbl[i].trigger = wdata[TRIG_BIT];
                        s_d.tbl[i].mask    = wdata[MASK_BIT];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= {NUM_LINES{RTE_RESET}};
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign ent_mask[g]           = s_q.tbl[g].mask;
        assign ent_vector[8*g +: 8]  = s_q.tbl[g].vector;
        assign ent_dest[8*g +: 8]    = s_q.tbl[g].dest;
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q)); // R7

    AST_HIGH_WORD_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_high |-> (rdata[23:0] == 24'h0)); // R5

endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick #(
    parameter int NUM_LINES = 24,
    parameter int ENT_W     = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   req,
    input  logic [8*NUM_LINES-1:0] vectors,
    input  logic [8*NUM_LINES-1:0] dests,
    output logic                   pick_valid,
    output logic [ENT_W-1:0]       pick_line,
    output logic [7:0]             pick_vector,
    output logic [7:0]             pick_dest
);

    always_comb begin
        pick_valid  = 1'b0;
        pick_line   = '0;
        pick_vector = '0;
        pick_dest   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_valid  = 1'b1;
                pick_line   = ENT_W'(i);
                pick_vector = vectors[8*i +: 8];
                pick_dest   = dests[8*i +: 8];
            end
        end
    end

    logic [NUM_LINES-1:0] below_pick;
    assign below_pick = (NUM_LINES'(1) << pick_line) - NUM_LINES'(1);

    AST_PICK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> req[pick_line]); // R10

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ((req & below_pick) == '0)); // R10

    AST_PICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |-> (req == '0)); // R10

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES  = 24,
    parameter int ADDR_W     = 8,
    parameter int IDX_W      = 8,
    parameter int TABLE_BASE = 'h10,
    parameter int VERSION    = 'h20,
    localparam int ENT_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_LINES-1:0]   irq_in,
    output logic [NUM_LINES-1:0]   req_out,
    output logic [NUM_LINES-1:0]   line_masked,
    output logic [8*NUM_LINES-1:0] line_vector,
    output logic [8*NUM_LINES-1:0] line_dest,
    output logic                   pick_valid,
    output logic [ENT_W-1:0]       pick_line,
    output logic [7:0]             pick_vector,
    output logic [7:0]             pick_dest
);

    logic [31:0]      tbl_rdata;
    logic             tbl_wr;
    logic [ENT_W-1:0] tbl_entry;
    logic             tbl_high;

    irq_route_window #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .NUM_LINES  (NUM_LINES),
        .ENT_W      (ENT_W),
        .IDX_OFS    ('h00),
        .WIN_OFS    ('h10),
        .ID_IDX     ('h00),
        .VER_IDX    ('h01),
        .TABLE_BASE (TABLE_BASE),
        .VERSION    (VERSION)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .tbl_rdata (tbl_rdata),
        .bus_rdata (bus_rdata),
        .tbl_wr    (tbl_wr),
        .tbl_entry (tbl_entry),
        .tbl_high  (tbl_high)
    );

    irq_route_entries #(
        .NUM_LINES (NUM_LINES),
        .ENT_W     (ENT_W)
    ) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr),
        .sel_entry  (tbl_entry),
        .sel_high   (tbl_high),
        .wdata      (bus_wdata),
        .rdata      (tbl_rdata),
        .ent_mask   (line_masked),
        .ent_vector (line_vector),
        .ent_dest   (line_dest)
    );

    typedef struct packed {
        logic [NUM_LINES-1:0] req;
    } top_state_t;

    top_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.req = irq_in & ~line_masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_out = s_q.req;

    irq_route_pick #(
        .NUM_LINES (NUM_LINES),
        .ENT_W     (ENT_W)
    ) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req_out),
        .vectors     (line_vector),
        .dests       (line_dest),
        .pick_valid  (pick_valid),
        .pick_line   (pick_line),
        .pick_vector (pick_vector),
        .pick_dest   (pick_dest)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_req_chk
        AST_REQ_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            req_out[g] |-> $past(irq_in[g])); // R8
        AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            req_out[g] |-> $past(!line_masked[g])); // R8
    end

endmodule

// File: tb/tb_irq_route_table.sv
module tb_irq_route_table;

    localparam int N = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    irq_in = '0;
    logic [N-1:0]    req_out;
    logic [N-1:0]    line_masked;
    logic [8*N-1:0]  line_vector;
    logic [8*N-1:0]  line_dest;
    logic            pick_valid;
    logic [4:0]      pick_line;
    logic [7:0]      pick_vector;
    logic [7:0]      pick_dest;

    always #2.5 clk = ~clk;

    irq_route_table dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_in      (irq_in),
        .req_out     (req_out),
        .line_masked (line_masked),
        .line_vector (line_vector),
        .line_dest   (line_dest),
        .pick_valid  (pick_valid),
        .pick_line   (pick_line),
        .pick_vector (pick_vector),
        .pick_dest   (pick_dest)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_wr   = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(8'h00, 32'(idx));
        bus_read(8'h10, d);
    endtask

    // {write?, index, write data, expected window read}
    localparam int NV = 13;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h00, 32'hA5FF_FFFF, 32'hA500_0000},  // R2 id field only
        {1'b1, 8'h01, 32'hFFFF_FFFF, 32'h0017_0020},  // R3 read-only version
        {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0001_80FF},  // R4 entry 0 low, masked
        {1'b1, 8'h11, 32'hFFFF_FFFF, 32'hFF00_0000},  // R5 entry 0 high
        {1'b1, 8'h3E, 32'h0000_0042, 32'h0000_0042},  // R4 entry 23 low, unmasked
        {1'b1, 8'h3F, 32'h1234_5678, 32'h1200_0000},  // R5 entry 23 high
        {1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 first index past table
        {1'b1, 8'h02, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 gap start
        {1'b1, 8'h0F, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 gap end
        {1'b0, 8'h12, 32'h0000_0000, 32'h0001_0000},  // R6 untouched entry 1
        {1'b1, 8'h14, 32'h0000_8031, 32'h0000_8031},  // R4 entry 2 low, unmasked
        {1'b1, 8'h15, 32'h0700_0000, 32'h0700_0000},  // R5 entry 2 high
        {1'b1, 8'hFF, 32'hFFFF_FFFF, 32'h0000_0000}   // R7 top index
    };
    string row_tag [NV] = '{"R2", "R3", "R4", "R5", "R4", "R5", "R7",
                            "R7", "R7", "R6", "R4", "R5", "R7"};

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;

        // Reset state
        bus_read(8'h00, rd);
        check("R6 index after reset", rd, 32'h0);
        check("R6 masks after reset", 32'(line_masked), 32'h00FF_FFFF);
        check("R6 no request after reset", {31'h0, pick_valid}, 32'h0);
        win_read(8'h00, rd);
        check("R6 id after reset", rd, 32'h0);
        win_read(8'h1A, rd);
        check("R6 entry 5 low after reset", rd, 32'h0001_0000);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            bus_write(8'h00, 32'(VEC[i][71:64]));
            if (VEC[i][72]) bus_write(8'h10, VEC[i][63:32]);
            bus_read(8'h10, rd);
            check(row_tag[i], rd, VEC[i][31:0]);
        end

        // R7: writes to unmapped indices left the id untouched
        win_read(8'h00, rd);
        check("R7 id kept after unmapped writes", rd, 32'hA500_0000);

        // R1: index readback, other offsets
        bus_write(8'h00, 32'hFFFF_FF3E);
        bus_read(8'h00, rd);
        check("R1 index readback", rd, 32'h0000_003E);
        bus_read(8'h04, rd);
        check("R1 other offset reads zero", rd, 32'h0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h00, rd);
        check("R1 other offset write keeps index", rd, 32'h0000_003E);
        bus_read(8'h10, rd);
        check("R1 other offset write keeps entry", rd, 32'h0000_0042);

        // R9: per-line fields
        check("R9 line 23 vector", 32'(line_vector[23*8 +: 8]), 32'h42);
        check("R9 line 23 dest", 32'(line_dest[23*8 +: 8]), 32'h12);
        check("R9 line 2 vector", 32'(line_vector[2*8 +: 8]), 32'h31);
        check("R9 masks", 32'(line_masked), 32'h007F_FFFB);

        // R8 / R10: requests and selection
        irq_in = '1;
        #1;
        check("R8 no request before edge", 32'(req_out), 32'h0);
        @(posedge clk);
        #1;
        check("R8 unmasked lines request", 32'(req_out), 32'h0080_0004);
        check("R10 pick lowest line", {pick_valid, 26'h0, pick_line}, {1'b1, 26'h0, 5'd2});
        check("R10 pick fields", {16'h0, pick_vector, pick_dest}, 32'h0000_3107);
        irq_in = 24'h80_0000;
        @(posedge clk);
        #1;
        check("R8 single line", 32'(req_out), 32'h0080_0000);
        check("R10 pick line 23", {pick_valid, 26'h0, pick_line}, {1'b1, 26'h0, 5'd23});
        check("R10 pick fields 23", {16'h0, pick_vector, pick_dest}, 32'h0000_4212);

        // R8: masking entry 2 again removes its request
        irq_in = '1;
        bus_write(8'h00, 32'h14);
        bus_write(8'h10, 32'h0001_8031);
        @(posedge clk);
        #1;
        check("R8 remasked line dropped", 32'(req_out), 32'h0080_0000);
        irq_in = '0;
        @(posedge clk);
        #1;
        check("R8 inputs low", 32'(req_out), 32'h0);
        check("R10 idle", {31'h0, pick_valid}, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule